// File: doc/BRIEF.md
# Data Access Fault Checker

This block sits beside the load/store stage of a processor pipeline. It examines every data address presented to it and flags two kinds of fault: a misaligned access, found by testing the low address bits against a size mask, and an access outside a stack window, found by comparing the address against a pair of limits. When a fault is found, the block records the offending address and writes a status word that describes the cause. It also issues a one-cycle exception request. Flushing the pipeline and jumping to a handler are left to the surrounding logic.

Accesses arrive as single-cycle strobes on `acc_valid` together with their attributes. The block accepts every strobe and applies no back-pressure. The pipeline may therefore present a new access on every clock. The recorded address and status word keep their values until the next fault overwrites them. The exceptions-enable input gates only the request for a misaligned access. A stack violation always raises the request.

Top module: `dax_checker`

## Requirements
- R1: An access is misaligned when `acc_addr` ANDed with `acc_mask` is non-zero. Mask 0 means byte, 1 means halfword and 3 means word, so a byte access is never misaligned.
- R2: On a misaligned access, `fault_addr` holds the access address from the cycle after the strobe.
- R3: The status word for a misaligned access has the cause code 1 in bits 4:0, the register number in bits 9:5 and the write flag in bit 10. Bit 11 is set exactly when the mask is 3. All other bits are 0.
- R4: A misaligned access raises `exc_req` only when `exc_en` is high. `fault_addr` and `fault_status` are updated even when `exc_en` is low.
- R5: When `stk_en` is high, an access is a stack violation if its address is unsigned-below `stk_low` or unsigned-above `stk_high`. An address equal to either limit is legal.
- R6: On a stack violation without misalignment, `fault_addr` captures the address and `fault_status` becomes 7 with all other bits 0. `exc_req` is raised whatever the value of `exc_en`.
- R7: When both checks fail on the same access, the misalignment result alone is recorded and gated, as set out in R3 and R4.
- R8: `exc_req` is a single-cycle pulse in the cycle after a faulting strobe. Without a strobe, `exc_req` is 0 and the recorded registers do not change.
- R9: When `stk_en` is low, no stack violation is reported, whatever the address.
- R10: After reset, `fault_addr`, `fault_status` and `exc_req` are all 0.
- R11: An access that passes both checks leaves `fault_addr` and `fault_status` unchanged and does not raise `exc_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_addr | input | AW (32) | Data address |
| acc_mask | input | MW (2) | Alignment mask: 0 byte, 1 halfword, 3 word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_reg | input | 5 | Register number of the data operand |
| stk_en | input | 1 | Enables the stack-window check |
| stk_low | input | AW (32) | Lowest legal stack address, inclusive |
| stk_high | input | AW (32) | Highest legal stack address, inclusive |
| exc_en | input | 1 | Exceptions enable; gates misalignment requests only |
| fault_addr | output | AW (32) | Address of the most recent fault |
| fault_status | output | SW (32) | Status word of the most recent fault |
| exc_req | output | 1 | Exception request pulse |

## Verification
The hardest case to reach is an access that fails both checks while exceptions are disabled. Here the stack rule alone would raise a request, but the misalignment result must win and keep `exc_req` low. The stimulus table contains this case directly: an odd halfword address above the high limit with `exc_en` low. A second entry repeats the double failure with exceptions enabled, to show that the misalignment status word is recorded. The addresses at each limit and one step outside each limit probe the inclusive unsigned comparison.

// File: rtl/dax_pkg.sv
package dax_pkg;
  localparam int CAUSE_W = 5;
  localparam int REG_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_STACK = 5'd7;
  localparam int REG_LSB = 5;
  localparam int WR_BIT = 10;
  localparam int WORD_BIT = 11;
  localparam int MIN_SW = 12;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_STACK = 2'd2
  } fault_e;
endpackage

// File: rtl/dax_align_chk.sv
module dax_align_chk #(
  parameter int MW = 2
) (
  input  logic [MW-1:0] addr_lsb,
  input  logic [MW-1:0] mask,
  output logic          misaligned,
  output logic          word_sized
);
  assign misaligned = |(addr_lsb & mask);
  assign word_sized = &mask;

  always_comb begin
    if (mask == '0) begin
      assert_byte_never_misaligned_R1: assert (!misaligned);
    end
  end
endmodule

// File: rtl/dax_stack_chk.sv
module dax_stack_chk #(
  parameter int AW = 32,
  parameter bit CHECK_PRESENT = 1'b1
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] low,
  input  logic [AW-1:0] high,
  output logic          violation
);
  generate
    if (CHECK_PRESENT) begin : g_check
      logic below, above;
      assign below = addr < low;
      assign above = addr > high;
      assign violation = en && (below || above);
    end else begin : g_none
      logic unused_in;
      assign unused_in = en ^ (|addr) ^ (|low) ^ (|high);
      assign violation = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!en) begin
      assert_disabled_quiet_R9: assert (!violation);
    end
  end
endmodule

// File: rtl/dax_fault_capture.sv
module dax_fault_capture
  import dax_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [AW-1:0]    addr,
  input  logic             misaligned,
  input  logic             word_sized,
  input  logic             is_write,
  input  logic [REG_W-1:0] reg_num,
  input  logic             stack_viol,
  input  logic             exc_en,
  output logic [AW-1:0]    ear_q,
  output logic [SW-1:0]    esr_q,
  output logic             req_q
);
  fault_e        kind;
  logic [SW-1:0] esr_d;
  logic          req_d;

  always_comb begin
    if (!valid) kind = FLT_NONE;
    else if (misaligned) kind = FLT_ALIGN;
    else if (stack_viol) kind = FLT_STACK;
    else kind = FLT_NONE;
  end

  always_comb begin
    esr_d = '0;
    req_d = 1'b0;
    case (kind)
      FLT_ALIGN: begin
        esr_d[CAUSE_W-1:0] = CAUSE_MISALIGN;
        esr_d[REG_LSB +: REG_W] = reg_num;
        esr_d[WR_BIT] = is_write;
        esr_d[WORD_BIT] = word_sized;
        req_d = exc_en;
      end
      FLT_STACK: begin
        esr_d[CAUSE_W-1:0] = CAUSE_STACK;
        req_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ear_q <= '0;
      esr_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (kind != FLT_NONE) begin
        ear_q <= addr;
        esr_q <= esr_d;
      end
    end
  end

  assert_mis_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && misaligned) |=> (ear_q == $past(addr)));
  assert_mis_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && misaligned) |=> (esr_q[CAUSE_W-1:0] == CAUSE_MISALIGN));
  assert_mis_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && misaligned) |=> (req_q == $past(exc_en)));
  assert_stack_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && stack_viol && !misaligned) |=> (req_q && esr_q[CAUSE_W-1:0] == CAUSE_STACK));
  assert_clean_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !misaligned && !stack_viol) |=> (!req_q && $stable(ear_q) && $stable(esr_q)));
endmodule

// File: rtl/dax_checker.sv
module dax_checker
  import dax_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 2,
  parameter int SW = 32,
  parameter bit STACK_CHECK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic [MW-1:0]    acc_mask,
  input  logic             acc_write,
  input  logic [REG_W-1:0] acc_reg,
  input  logic             stk_en,
  input  logic [AW-1:0]    stk_low,
  input  logic [AW-1:0]    stk_high,
  input  logic             exc_en,
  output logic [AW-1:0]    fault_addr,
  output logic [SW-1:0]    fault_status,
  output logic             exc_req
);
  logic mis, word, viol;

  initial begin
    assert_width_ok_R3: assert (SW >= MIN_SW && MW <= AW);
  end

  dax_align_chk #(.MW(MW)) u_align (
    .addr_lsb  (acc_addr[MW-1:0]),
    .mask      (acc_mask),
    .misaligned(mis),
    .word_sized(word)
  );

  dax_stack_chk #(.AW(AW), .CHECK_PRESENT(STACK_CHECK)) u_stack (
    .en       (stk_en),
    .addr     (acc_addr),
    .low      (stk_low),
    .high     (stk_high),
    .violation(viol)
  );

  dax_fault_capture #(.AW(AW), .SW(SW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (acc_valid),
    .addr      (acc_addr),
    .misaligned(mis),
    .word_sized(word),
    .is_write  (acc_write),
    .reg_num   (acc_reg),
    .stack_viol(viol),
    .exc_en    (exc_en),
    .ear_q     (fault_addr),
    .esr_q     (fault_status),
    .req_q     (exc_req)
  );

  assert_req_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> $past(acc_valid));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> (!exc_req && $stable(fault_addr) && $stable(fault_status)));
endmodule

// File: tb/dax_checker_test.sv
module dax_checker_test;
  localparam logic [31:0] LO = 32'h0000_1000;
  localparam logic [31:0] HI = 32'h0000_1FFF;

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  mask;
    logic        wr;
    logic [4:0]  rg;
    logic        se;
    logic        ee;
    logic        fault;
    logic        req;
    logic [31:0] esr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{32'h0000_1004, 2'd3, 1'b0, 5'd1,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},   // R11 aligned word
    '{32'h0000_1001, 2'd1, 1'b0, 5'd3,  1'b1, 1'b1, 1'b1, 1'b1, 32'h061}, // R1 R3 halfword
    '{32'h0000_1002, 2'd3, 1'b1, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1, 32'hFE1}, // R3 word store
    '{32'h0000_1003, 2'd3, 1'b0, 5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 32'h8A1}, // R4 gated
    '{32'h0000_1002, 2'd1, 1'b1, 5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},   // R1 halfword ok
    '{32'h0000_1003, 2'd0, 1'b0, 5'd7,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},   // R1 byte
    '{32'h0000_1000, 2'd3, 1'b0, 5'd2,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},   // R5 at low
    '{32'h0000_0FFC, 2'd3, 1'b0, 5'd2,  1'b1, 1'b1, 1'b1, 1'b1, 32'h7},   // R5 R6 below
    '{32'h0000_1FFF, 2'd0, 1'b1, 5'd2,  1'b1, 1'b1, 1'b0, 1'b0, 32'h0},   // R5 at high
    '{32'h0000_2000, 2'd0, 1'b0, 5'd2,  1'b1, 1'b0, 1'b1, 1'b1, 32'h7},   // R6 above, ee off
    '{32'h0000_0FFD, 2'd1, 1'b1, 5'd2,  1'b1, 1'b1, 1'b1, 1'b1, 32'h441}, // R7 both
    '{32'h0000_3000, 2'd3, 1'b0, 5'd9,  1'b0, 1'b1, 1'b0, 1'b0, 32'h0},   // R9 check off
    '{32'h0000_2001, 2'd1, 1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 32'h001}  // R7 both, ee off
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0] acc_mask = '0;
  logic acc_write = 1'b0;
  logic [4:0] acc_reg = '0;
  logic stk_en = 1'b0;
  logic [31:0] stk_low = LO;
  logic [31:0] stk_high = HI;
  logic exc_en = 1'b0;
  logic [31:0] fault_addr;
  logic [31:0] fault_status;
  logic exc_req;

  int checks = 0;
  int failures = 0;
  logic [31:0] m_ear = '0;
  logic [31:0] m_esr = '0;

  always #4 clk = ~clk;

  dax_checker uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_mask(acc_mask), .acc_write(acc_write), .acc_reg(acc_reg),
    .stk_en(stk_en), .stk_low(stk_low), .stk_high(stk_high), .exc_en(exc_en),
    .fault_addr(fault_addr), .fault_status(fault_status), .exc_req(exc_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic valid);
    acc_valid = valid;
    acc_addr = v.addr;
    acc_mask = v.mask;
    acc_write = v.wr;
    acc_reg = v.rg;
    stk_en = v.se;
    exc_en = v.ee;
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 addr", fault_addr, 32'h0);
    check("R10 status", fault_status, 32'h0);
    check("R10 req", {31'h0, exc_req}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i], 1'b1);
      @(negedge clk);
      if (TBL[i].fault) begin
        m_ear = TBL[i].addr;
        m_esr = TBL[i].esr;
      end
      check($sformatf("R2/R6/R11 addr v%0d", i), fault_addr, m_ear);
      check($sformatf("R3/R6/R7 status v%0d", i), fault_status, m_esr);
      check($sformatf("R4/R6/R7 req v%0d", i), {31'h0, exc_req}, {31'h0, TBL[i].req});
      acc_valid = 1'b0;
      @(negedge clk);
      check($sformatf("R8 pulse end v%0d", i), {31'h0, exc_req}, 32'h0);
    end

    // R8: a faulting pattern without a strobe changes nothing
    drive(TBL[7], 1'b0);
    @(negedge clk);
    @(negedge clk);
    check("R8 idle req", {31'h0, exc_req}, 32'h0);
    check("R8 idle addr", fault_addr, m_ear);
    check("R8 idle status", fault_status, m_esr);

    // R8: back-to-back faulting strobes give one pulse each
    drive(TBL[1], 1'b1);
    @(negedge clk);
    check("R8 b2b first", {31'h0, exc_req}, 32'h1);
    drive(TBL[9], 1'b1);
    @(negedge clk);
    check("R8 b2b second req", {31'h0, exc_req}, 32'h1);
    check("R6 b2b status", fault_status, 32'h7);
    acc_valid = 1'b0;
    @(negedge clk);
    check("R8 b2b end", {31'h0, exc_req}, 32'h0);

    // R10: reset clears captured state
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset addr", fault_addr, 32'h0);
    check("R10 re-reset status", fault_status, 32'h0);
    rst_n = 1'b1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule